// File: doc/BRIEF.md
# Circular trace capture buffer

This block is a trace sink. It takes a stream of 32-bit trace words over a valid/ready handshake and writes them into an on-chip RAM that it treats as a ring. Once the write pointer reaches the last entry it goes back to entry 0. From then on the oldest data in the ring always sits at the current write position.

Software controls the block through a small bank of 32-bit registers. The usual session runs in five steps:
1. Select ring mode.
2. Program a post-trigger word count.
3. Enable capture.
4. Let a trigger input, or a flush that software requests, start the countdown that ends capture.
5. Once the status register reports the block idle, drain the captured words oldest first through a data register.

The data register returns an all-ones value when there is nothing left to read. While capture is stopped the input handshake refuses words, so nothing is dropped during readout. The register read data is combinational from the address. A read of the data register takes effect at the clock edge on which the read strobe is high.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, the status register (0x00C) reads 0x4, the capacity register (0x004) reads DEPTH, the data register (0x010) reads 0xFFFFFFFF, the flush control register (0x304) reads 0, and tr_ready is low.
- R2: Writing 1 to bit 0 of the control register (0x020) while it holds 0 clears both pointers, the wrap flag, the trigger flag and the stopped state. tr_ready is high only while enabled, not stopped, and the mode register (0x028, bits 1:0) holds 0. Mode values 1 and 2 keep tr_ready low.
- R3: Each accepted word is stored at the write pointer (read at 0x018), which then increments modulo DEPTH. Status bit 0 becomes 1 on the first wrap and stays 1 until the next enable.
- R4: When flush control bit 8 is 1, a high trig_in while tr_ready is high sets status bit 1. The block then accepts exactly N more words, where N is the count register (0x01C), and lowers tr_ready. When bit 8 is 0, trig_in has no effect.
- R5: Writing flush control with bit 6 set makes bit 6 read 1 in the next cycle and 0 in the cycle after. If bit 12 is 1 at completion and capture is running, the N-word countdown of R4 starts.
- R6: Status bit 2 reads 1 exactly when capture is not running (stopped or disabled) and no flush is pending.
- R7: When capture stops, the read pointer (0x014) is loaded with the write pointer if the ring has wrapped, and with 0 otherwise. Data register reads then return the captured words oldest first, wrapping at DEPTH.
- R8: The data register returns 0xFFFFFFFF and does not advance once all captured words have been returned, and also while capture is running.
- R9: Writes to the read and write pointer registers take effect only while control bit 0 is 0. Otherwise they are ignored.
- R10: Writing 0 to control bit 0 during capture stops it, lowers tr_ready, and prepares readout as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed only for the data register) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tr_valid | input | 1 | Trace word valid |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Block accepts a trace word this cycle |
| trig_in | input | 1 | Trigger event input |

## Verification
The bench sweeps the number of captured words from zero to beyond two ring lengths. This catches a design that drains from entry 0 after a wrap, or that sets the wrap flag one word early or late; either fault returns misordered words or a wrong read pointer. It also sweeps the trigger position against post-trigger counts 0 to 3. An off-by-one in the countdown shows up as one word too many or too few before tr_ready falls. Other checks cover an ignored trigger, a single-cycle flush pulse, flush-driven stop, pointer writes while enabled, and reads of the data register during capture. A design that lets any of these through would move a pointer or return live data where the sentinel is expected.

// File: rtl/trace_ring_pkg.sv
package trace_ring_pkg;

   localparam int REG_AW = 12;

   // register byte offsets (software decodes these)
   localparam logic [REG_AW-1:0] OFF_DEPTH = 12'h004;
   localparam logic [REG_AW-1:0] OFF_STAT  = 12'h00C;
   localparam logic [REG_AW-1:0] OFF_RDATA = 12'h010;
   localparam logic [REG_AW-1:0] OFF_RPTR  = 12'h014;
   localparam logic [REG_AW-1:0] OFF_WPTR  = 12'h018;
   localparam logic [REG_AW-1:0] OFF_TCNT  = 12'h01C;
   localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h020;
   localparam logic [REG_AW-1:0] OFF_MODE  = 12'h028;
   localparam logic [REG_AW-1:0] OFF_FSTAT = 12'h300;
   localparam logic [REG_AW-1:0] OFF_FCTRL = 12'h304;

   // flush control bit positions
   localparam int FC_FLUSH  = 6;
   localparam int FC_TRIG   = 8;
   localparam int FC_STOPFL = 12;

   typedef enum logic [1:0] {
      MODE_RING   = 2'd0,
      MODE_SWFIFO = 2'd1,
      MODE_HWFIFO = 2'd2
   } cap_mode_e;

endpackage

// File: rtl/trace_ring_mem.sv
module trace_ring_mem #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [PW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [PW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/trace_ring_ptr.sv
module trace_ring_ptr #(
   parameter int DEPTH = 16,
   parameter int PW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   input  logic          inc,
   output logic [PW-1:0] ptr,
   output logic [PW-1:0] nxt,
   output logic          wrap
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   logic [PW-1:0] step;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         // natural overflow wraps at DEPTH
         assign step = ptr + 1'b1;
      end else begin : g_cmp
         assign step = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   assign nxt  = load ? load_val : (inc ? step : ptr);
   assign wrap = inc && !load && (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= nxt;
   end

endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
   import trace_ring_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TCW   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tr_valid,
   input  logic [31:0]       tr_data,
   output logic              tr_ready,
   input  logic              trig_in
);

   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("trace_ring_sink: DEPTH must be at least 2");
      end
      if (TCW < 1 || TCW > 32) begin : g_bad_tcw
         $error("trace_ring_sink: TCW must be 1..32");
      end
   endgenerate

   // architectural state
   logic            en, stopped, wrapped, triggered, flush_pend;
   logic            trig_en, stop_fl;
   cap_mode_e       mode;
   logic [TCW-1:0]  tcnt, tleft;
   logic [CW-1:0]   rd_left;

   logic [PW-1:0]   wptr, wptr_nx, rptr, rptr_nx;
   logic            wrap_pulse, rwrap_unused;
   logic [31:0]     mem_q;

   // decode and control
   logic wr_ctrl, wr_mode, wr_tcnt, wr_fctrl, wr_wptr, wr_rptr;
   logic en_rise, en_fall, capturing, count_done, acc, halt;
   logic readable, have_data, rd_pop, trig_start, wrap_nx, idle;
   logic wdata_unused;

   assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
   assign wr_mode  = reg_wr && (reg_addr == OFF_MODE);
   assign wr_tcnt  = reg_wr && (reg_addr == OFF_TCNT);
   assign wr_fctrl = reg_wr && (reg_addr == OFF_FCTRL);
   assign wr_wptr  = reg_wr && (reg_addr == OFF_WPTR);
   assign wr_rptr  = reg_wr && (reg_addr == OFF_RPTR);

   assign en_rise    = wr_ctrl && reg_wdata[0] && !en;
   assign en_fall    = wr_ctrl && !reg_wdata[0] && en;
   assign capturing  = en && !stopped && (mode == MODE_RING);
   assign count_done = triggered && (tleft == '0);
   assign tr_ready   = capturing && !count_done;
   assign acc        = tr_valid && tr_ready;
   assign halt       = en && !stopped && (count_done || en_fall);
   assign readable   = stopped || !en;
   assign have_data  = readable && (rd_left != '0);
   assign rd_pop     = reg_rd && (reg_addr == OFF_RDATA) && have_data;
   assign trig_start = tr_ready && !triggered &&
                       ((trig_in && trig_en) || (flush_pend && stop_fl));
   assign wrap_nx    = wrapped || wrap_pulse;
   assign idle       = readable && !flush_pend;
   assign wdata_unused = ^reg_wdata;

   trace_ring_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (en_rise || (wr_wptr && !en)),
      .load_val (en_rise ? '0 : reg_wdata[PW-1:0]),
      .inc      (acc),
      .ptr      (wptr),
      .nxt      (wptr_nx),
      .wrap     (wrap_pulse)
   );

   logic [PW-1:0] rload_val;
   always_comb begin
      if (en_rise)  rload_val = '0;
      else if (halt) rload_val = wrap_nx ? wptr_nx : '0;
      else          rload_val = reg_wdata[PW-1:0];
   end

   trace_ring_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (en_rise || halt || (wr_rptr && !en)),
      .load_val (rload_val),
      .inc      (rd_pop),
      .ptr      (rptr),
      .nxt      (rptr_nx),
      .wrap     (rwrap_unused)
   );

   trace_ring_mem #(.DEPTH(DEPTH), .DW(32), .PW(PW)) u_mem (
      .clk   (clk),
      .we    (acc),
      .waddr (wptr),
      .wdata (tr_data),
      .raddr (rptr),
      .rdata (mem_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= 1'b0;
         mode       <= MODE_RING;
         tcnt       <= '0;
         trig_en    <= 1'b0;
         stop_fl    <= 1'b0;
         flush_pend <= 1'b0;
         stopped    <= 1'b0;
         wrapped    <= 1'b0;
         triggered  <= 1'b0;
         tleft      <= '0;
         rd_left    <= '0;
      end else begin
         if (wr_ctrl) en   <= reg_wdata[0];
         if (wr_mode) mode <= cap_mode_e'(reg_wdata[1:0]);
         if (wr_tcnt) tcnt <= reg_wdata[TCW-1:0];
         if (wr_fctrl) begin
            trig_en <= reg_wdata[FC_TRIG];
            stop_fl <= reg_wdata[FC_STOPFL];
         end
         if (wr_fctrl && reg_wdata[FC_FLUSH]) flush_pend <= 1'b1;
         else if (flush_pend)                 flush_pend <= 1'b0;

         if (en_rise) begin
            stopped   <= 1'b0;
            wrapped   <= 1'b0;
            triggered <= 1'b0;
            tleft     <= '0;
            rd_left   <= '0;
         end else begin
            if (wrap_pulse) wrapped <= 1'b1;
            if (halt) begin
               stopped <= 1'b1;
               rd_left <= wrap_nx ? CW'(DEPTH) : CW'(wptr_nx);
            end else if (rd_pop) begin
               rd_left <= rd_left - 1'b1;
            end
            if (trig_start) begin
               triggered <= 1'b1;
               tleft     <= tcnt;
            end else if (acc && triggered && (tleft != '0)) begin
               tleft <= tleft - 1'b1;
            end
         end
      end
   end

   // register read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFF_DEPTH: reg_rdata = 32'(DEPTH);
         OFF_STAT:  reg_rdata = {29'b0, idle, triggered, wrapped};
         OFF_RDATA: reg_rdata = have_data ? mem_q : '1;
         OFF_RPTR:  reg_rdata = 32'(rptr);
         OFF_WPTR:  reg_rdata = 32'(wptr);
         OFF_TCNT:  reg_rdata = 32'(tcnt);
         OFF_CTRL:  reg_rdata = {31'b0, en};
         OFF_MODE:  reg_rdata = {30'b0, mode};
         OFF_FSTAT: reg_rdata = {30'b0, stopped, flush_pend};
         OFF_FCTRL: begin
            reg_rdata[FC_FLUSH]  = flush_pend;
            reg_rdata[FC_TRIG]   = trig_en;
            reg_rdata[FC_STOPFL] = stop_fl;
         end
         default:   reg_rdata = '0;
      endcase
   end

   // R3: the wrap flag is sticky while capture stays enabled
   assert_wrap_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrapped && en) |=> wrapped);

   // R4: a stop persists until a fresh enable, which needs a disable first
   assert_stop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && en) |=> (stopped && !tr_ready));

   // R5: a pending flush completes in one cycle unless re-requested
   assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_pend && !(wr_fctrl && reg_wdata[FC_FLUSH])) |=> !flush_pend);

   // R7: entering the stopped state leaves readout at the oldest word
   assert_halt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped) |-> (rptr == (wrapped ? wptr : '0)));

   // R8: the readout count never exceeds ring capacity
   assert_readout_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_left <= CW'(DEPTH));

   // R9: with capture enabled the write pointer moves only on accepted words
   assert_wptr_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !acc) |=> $stable(wptr));

endmodule

// File: tb/tb_trace_ring_sink.sv
module tb_trace_ring_sink;
   import trace_ring_pkg::*;

   localparam int CLK_NS = 10;
   localparam int D      = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tr_valid = 1'b0;
   logic [31:0] tr_data = '0;
   logic        tr_ready;
   logic        trig_in = 1'b0;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_NS/2) clk = ~clk;

   trace_ring_sink #(.DEPTH(D), .TCW(16)) dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tr_valid(tr_valid), .tr_data(tr_data), .tr_ready(tr_ready),
      .trig_in(trig_in)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(posedge clk);
      #1 reg_rd = 1'b0;
   endtask

   task automatic push(input logic [31:0] d, input logic tg, output logic acc);
      @(negedge clk);
      tr_valid = 1'b1; tr_data = d; trig_in = tg;
      #1 acc = tr_ready;
      @(posedge clk);
      #1 tr_valid = 1'b0; trig_in = 1'b0;
   endtask

   task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   // drains the ring; words were captured as base+index
   task automatic readout(input int n, input logic [31:0] base);
      int cnt   = (n >= D) ? D : n;
      int first = (n >= D) ? n - D : 0;
      for (int i = 0; i < cnt; i++)
         rdchk("R7 oldest-first readout", OFF_RDATA, base + 32'(first + i));
      rdchk("R8 sentinel after drain", OFF_RDATA, 32'hFFFF_FFFF);
   endtask

   task automatic restart(input logic [31:0] tc, input logic [31:0] fc);
      wr(OFF_CTRL, 0);
      wr(OFF_MODE, 0);
      wr(OFF_TCNT, tc);
      wr(OFF_FCTRL, fc);
      wr(OFF_CTRL, 1);
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic acc;
      logic [31:0] base;
      int cnt;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk); #1 chk("R1 tr_ready after reset", 32'(tr_ready), 0);
      rdchk("R1 status", OFF_STAT, 32'h4);
      rdchk("R1 capacity", OFF_DEPTH, 32'(D));
      rdchk("R1 data sentinel", OFF_RDATA, 32'hFFFF_FFFF);
      rdchk("R1 flush control", OFF_FCTRL, 32'h0);

      // R2 mode decoding
      wr(OFF_MODE, 2);
      wr(OFF_CTRL, 1);
      @(negedge clk); #1 chk("R2 ready low in mode 2", 32'(tr_ready), 0);
      wr(OFF_MODE, 1);
      @(negedge clk); #1 chk("R2 ready low in mode 1", 32'(tr_ready), 0);
      wr(OFF_MODE, 0);
      @(negedge clk); #1 chk("R2 ready high in mode 0", 32'(tr_ready), 1);

      // R3 R7 R10 sweep over captured lengths, stop by disable
      for (int n = 0; n <= 2 * D + 2; n++) begin
         base = 32'(n) << 16;
         restart(0, 0);
         cnt = 0;
         for (int i = 0; i < n; i++) begin
            push(base + 32'(i), 1'b0, acc);
            if (acc) cnt++;
         end
         chk("R3 all words accepted", 32'(cnt), 32'(n));
         rdchk("R3 wrap flag while running", OFF_STAT, (n >= D) ? 32'h1 : 32'h0);
         rdchk("R3 write pointer", OFF_WPTR, 32'(n % D));
         rdchk("R8 sentinel during capture", OFF_RDATA, 32'hFFFF_FFFF);
         wr(OFF_CTRL, 0);
         @(negedge clk); #1 chk("R10 ready low after disable", 32'(tr_ready), 0);
         rdchk("R10 read pointer at stop", OFF_RPTR, (n >= D) ? 32'(n % D) : 32'h0);
         rdchk("R6 idle after disable", OFF_STAT, ((n >= D) ? 32'h1 : 32'h0) | 32'h4);
         readout(n, base);
      end

      // R4 trigger sweep: position and post-trigger count
      for (int trg = 0; trg <= 3; trg++) begin
         for (int pre = 0; pre <= D + 1; pre++) begin
            int tot;
            base = 32'h8000_0000 | (32'(trg) << 20) | (32'(pre) << 12);
            restart(32'(trg), 32'h100);
            for (int i = 0; i < pre; i++) push(base + 32'(i), 1'b0, acc);
            push(base + 32'(pre), 1'b1, acc);
            chk("R4 trigger word accepted", 32'(acc), 1);
            cnt = 0;
            for (int k = 0; k < 8; k++) begin
               push(base + 32'(pre + 1 + cnt), 1'b0, acc);
               if (!acc) break;
               cnt++;
            end
            chk("R4 post-trigger word count", 32'(cnt), 32'(trg));
            tot = pre + 1 + trg;
            rdchk("R4 status after trigger stop", OFF_STAT,
                  ((tot >= D) ? 32'h1 : 32'h0) | 32'h6);
            readout(tot, base);
         end
      end

      // R4 trigger ignored, R8 no advance during capture, R9 pointer writes
      base = 32'hA000_0000;
      restart(0, 0);
      for (int i = 0; i < 3; i++) begin
         push(base + 32'(i), 1'b1, acc);
         chk("R4 ignored trigger keeps accepting", 32'(acc), 1);
      end
      rdchk("R4 trigger flag stays clear", OFF_STAT, 32'h0);
      rdchk("R8 sentinel while running", OFF_RDATA, 32'hFFFF_FFFF);
      wr(OFF_RPTR, 5);
      rdchk("R9 read pointer write ignored when enabled", OFF_RPTR, 32'h0);
      wr(OFF_WPTR, 6);
      rdchk("R9 write pointer write ignored when enabled", OFF_WPTR, 32'h3);
      wr(OFF_CTRL, 0);
      readout(3, base);
      wr(OFF_RPTR, 1);
      rdchk("R9 read pointer write when disabled", OFF_RPTR, 32'h1);
      wr(OFF_WPTR, 6);
      rdchk("R9 write pointer write when disabled", OFF_WPTR, 32'h6);

      // R5 flush with stop: countdown of 2 after flush completes
      base = 32'hB000_0000;
      restart(2, 32'h1000);
      for (int i = 0; i < 3; i++) push(base + 32'(i), 1'b0, acc);
      wr(OFF_FCTRL, 32'h1040);
      rdchk("R5 flush bit set next cycle", OFF_FCTRL, 32'h1040);
      rdchk("R5 flush bit self-clears", OFF_FCTRL, 32'h1000);
      rdchk("R6 not idle during countdown", OFF_STAT, 32'h2);
      cnt = 0;
      for (int k = 0; k < 6; k++) begin
         push(base + 32'(3 + cnt), 1'b0, acc);
         if (!acc) break;
         cnt++;
      end
      chk("R5 words after flush stop", 32'(cnt), 2);
      rdchk("R5 stopped status", OFF_STAT, 32'h6);
      readout(5, base);

      // R5 flush without stop keeps capturing
      restart(0, 0);
      wr(OFF_FCTRL, 32'h40);
      rdchk("R5 plain flush pending", OFF_FCTRL, 32'h40);
      rdchk("R5 plain flush done", OFF_FCTRL, 32'h0);
      push(32'h1234_5678, 1'b0, acc);
      chk("R5 capture continues after plain flush", 32'(acc), 1);
      rdchk("R5 no trigger from plain flush", OFF_STAT, 32'h0);

      // R6 flush pending while disabled hides idle
      wr(OFF_CTRL, 0);
      wr(OFF_FCTRL, 32'h40);
      rdchk("R6 idle low while flush pending", OFF_STAT, 32'h0);
      rdchk("R6 idle high after flush", OFF_STAT, 32'h4);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule